// File: doc/BRIEF.md
# Retriggerable Raster Timing Generator

This block produces the line and field timing of a video raster from a pixel clock. A line counter steps once per clock and wraps at a programmed line length. A second counter steps once per half line and wraps after twice the programmed number of lines per field. A field parity flag flips at every field boundary. A colour sequence phase counts completed frames over a two-frame or a four-frame cycle. Horizontal sync, vertical sync, field parity and sequence phase are decoded from these counters.

In slave mode the block follows an external raster. Two reference inputs each pass through a synchronizer and an edge detector, and each input has its own choice of rising or falling edge. A single detected edge overwrites the counters at once with programmed offsets. There is no filtering and no phase tracking. Because the counter is loaded with an offset, the next sync can be placed a set distance ahead of the trigger position in the following period. Individual enables decide which parts of the timing state each trigger reloads. Either reference input can realign the line counter. Only the first input realigns the vertical counter, the field flag and the sequence phase.

Top module: `raster_sync_gen`

## Requirements
- R1: While `rst_n` is low, the line counter and the half-line counter are 0, `hsync` and `vsync` are high (given `hs_width` > 0), and `field_odd` and `seq_phase` are 0.
- R2: Without a reload, the line counter counts 0 to `line_len`-1 and wraps. `hsync` is high while the count is below `hs_width`, so it spans the first `hs_width` clocks of each line.
- R3: The half-line counter steps on the clock after the line counter holds `line_len`/2-1 or `line_len`-1 (`line_len` even). It wraps after 2*`field_lines` half lines. `vsync` is high while it holds 0. After a horizontal reload, half-line steps follow the realigned line counter.
- R4: Each half-line counter wrap inverts `field_odd`. A wrap that occurs with `field_odd` = 1 completes a frame and advances `seq_phase`. When `seq_long` = 0 the phase counts modulo 2 (four-field sequence). When `seq_long` = 1 it counts modulo 4 (eight-field sequence).
- R5: Each reference input passes through a two-stage synchronizer and a previous-sample compare. Its `*_fall` select chooses the trigger edge: 0 for rising, 1 for falling. The reload lands on the third rising clock edge after the input changes. The edge that is not selected has no effect.
- R6: A horizontal trigger loads the line counter with `h_ofs`. It occurs when `slave_en` and `ld_h_en` are high and a selected edge arrives on `ref_a` with `h_src_a` = 1, or on `ref_b` with `h_src_b` = 1. The next `hsync` therefore starts `line_len`-`h_ofs` clocks after the load. With `h_ofs` = 0, `hsync` is high from the load cycle.
- R7: When `slave_en` and `ld_v_en` are high, a selected edge on `ref_a` loads the half-line counter with `v_ofs` (`v_ofs` < 2*`field_lines`). With `v_ofs` = 0, `vsync` is high from the load cycle. With a value N, the next `vsync` starts 2*`field_lines`-N half lines later, which is N half lines ahead of the trigger's position in the next field.
- R8: A selected `ref_a` edge in slave mode clears `field_odd` to 0 when `ld_fld_en` is high. It clears `seq_phase` to 0 when `ld_seq_en` is high.
- R9: With `slave_en` low, reference edges change nothing. With `slave_en` high, a counter whose load enable is low keeps free-running through a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_en | input | 1 | Allow reference edges to reload timing state |
| ref_a | input | 1 | First external reference (horizontal and vertical) |
| ref_b | input | 1 | Second external reference (horizontal only) |
| ref_a_fall | input | 1 | Edge select for `ref_a`: 0 rising, 1 falling |
| ref_b_fall | input | 1 | Edge select for `ref_b`: 0 rising, 1 falling |
| h_src_a | input | 1 | `ref_a` edges may reload the line counter |
| h_src_b | input | 1 | `ref_b` edges may reload the line counter |
| ld_h_en | input | 1 | Enable line counter reload |
| ld_v_en | input | 1 | Enable half-line counter reload |
| ld_fld_en | input | 1 | Enable field flag clear |
| ld_seq_en | input | 1 | Enable sequence phase clear |
| seq_long | input | 1 | 0: four-field sequence, 1: eight-field sequence |
| line_len | input | HW (11) | Clocks per line |
| field_lines | input | VW (10) | Lines per field |
| hs_width | input | SW (8) | Horizontal sync length in clocks |
| h_ofs | input | HW (11) | Line counter reload value |
| v_ofs | input | VOW (5) | Half-line counter reload value |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync (half line 0) |
| field_odd | output | 1 | Field parity |
| seq_phase | output | 2 | Colour sequence phase |

## Verification
The bench keeps the default parameter widths, including the full 11-bit line and offset fields. Through the ports it programs a 20-clock line with 5 or 20 lines per field, which makes a field 100 or 400 clocks long. With these values, field flips, both sequence lengths wrapping, and a 31-half-line vertical offset all occur within a few thousand cycles. The runs cover reloads from both inputs with each edge polarity, ignored opposite edges, slave mode off, and per-counter enables.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int SEQ_W = 2;

  typedef logic [15:0] cnt_t;

  // next value of a counter that wraps after len-1
  function automatic cnt_t wrap_step(cnt_t cur, cnt_t len);
    return (cur >= len - 16'd1) ? 16'd0 : cur + 16'd1;
  endfunction

  // true when the current clock is the last one of a half line
  function automatic logic half_line_end(cnt_t cur, cnt_t len);
    return (cur == len - 16'd1) || (cur == (len >> 1) - 16'd1);
  endfunction

  // horizontal sync window
  function automatic logic in_sync_window(cnt_t cur, cnt_t width);
    return cur < width;
  endfunction

  // sequence phase step: modulo 2 or modulo 4
  function automatic logic [SEQ_W-1:0] seq_next(logic [SEQ_W-1:0] cur, logic long_seq);
    return long_seq ? cur + 2'd1 : {1'b0, ~cur[0]};
  endfunction

endpackage

// File: rtl/ref_edge_detect.sv
module ref_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic fall_sel,
  output logic pulse
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= din;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  logic cur_s, prev_s;
  assign cur_s  = chain[STAGES-1];
  assign prev_s = chain[STAGES];
  assign pulse  = fall_sel ? (prev_s & ~cur_s) : (cur_s & ~prev_s);

  // R5: a detected edge lasts exactly one clock
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> (!pulse || fall_sel != $past(fall_sel)));

endmodule

// File: rtl/line_counter.sv
module line_counter
  import raster_pkg::*;
#(
  parameter int HW = 11,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] line_len,
  input  logic [SW-1:0] hs_width,
  input  logic          load,
  input  logic [HW-1:0] load_val,
  output logic          half_tick,
  output logic          hsync
);
  logic [HW-1:0] hcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hcnt <= '0;
    else if (load) hcnt <= load_val;
    else           hcnt <= HW'(wrap_step(cnt_t'(hcnt), cnt_t'(line_len)));
  end

  assign half_tick = half_line_end(cnt_t'(hcnt), cnt_t'(line_len));
  assign hsync     = in_sync_window(cnt_t'(hcnt), cnt_t'(hs_width));

  // R2: free-running increment and wrap
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && hcnt < line_len - 1'b1) |=> hcnt == $past(hcnt) + 1'b1);
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && hcnt == line_len - 1'b1) |=> hcnt == '0);
  // R6: hard reload with the offset
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> hcnt == $past(load_val));

endmodule

// File: rtl/field_counter.sv
module field_counter
  import raster_pkg::*;
#(
  parameter int VW  = 10,
  parameter int VHW = VW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VW-1:0]    field_lines,
  input  logic             seq_long,
  input  logic             half_tick,
  input  logic             v_load,
  input  logic [VHW-1:0]   v_load_val,
  input  logic             fld_clear,
  input  logic             seq_clear,
  output logic             vsync,
  output logic             field_odd,
  output logic [SEQ_W-1:0] seq_phase
);
  logic [VHW-1:0] vcnt;
  logic [VHW-1:0] halves;
  logic           v_wrap;
  logic           frame_done;

  assign halves     = {field_lines, 1'b0};
  assign v_wrap     = half_tick && (vcnt >= halves - 1'b1);
  assign frame_done = v_wrap && field_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         vcnt <= '0;
    else if (v_load)    vcnt <= v_load_val;
    else if (half_tick) vcnt <= VHW'(wrap_step(cnt_t'(vcnt), cnt_t'(halves)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         field_odd <= 1'b0;
    else if (fld_clear) field_odd <= 1'b0;
    else if (v_wrap)    field_odd <= ~field_odd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seq_phase <= '0;
    else if (seq_clear)  seq_phase <= '0;
    else if (frame_done) seq_phase <= seq_next(seq_phase, seq_long);
  end

  assign vsync = (vcnt == '0);

  // R3: half-line counter only moves on half-line boundaries or reloads
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_tick && !v_load) |=> $stable(vcnt));
  // R4: each wrap flips the field flag
  a_r4_field_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (v_wrap && !fld_clear) |=> field_odd != $past(field_odd));
  a_r4_seq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_done && !seq_clear) |=> $stable(seq_phase));
  // R7: vertical reload value
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    v_load |=> vcnt == $past(v_load_val));
  // R8: clears go to the first state
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_clear && seq_clear) |=> (!field_odd && seq_phase == '0));

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
  import raster_pkg::*;
#(
  parameter int HW          = 11,
  parameter int VW          = 10,
  parameter int SW          = 8,
  parameter int VOW         = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slave_en,
  input  logic             ref_a,
  input  logic             ref_b,
  input  logic             ref_a_fall,
  input  logic             ref_b_fall,
  input  logic             h_src_a,
  input  logic             h_src_b,
  input  logic             ld_h_en,
  input  logic             ld_v_en,
  input  logic             ld_fld_en,
  input  logic             ld_seq_en,
  input  logic             seq_long,
  input  logic [HW-1:0]    line_len,
  input  logic [VW-1:0]    field_lines,
  input  logic [SW-1:0]    hs_width,
  input  logic [HW-1:0]    h_ofs,
  input  logic [VOW-1:0]   v_ofs,
  output logic             hsync,
  output logic             vsync,
  output logic             field_odd,
  output logic [SEQ_W-1:0] seq_phase
);
  localparam int NREF = 2;
  localparam int VHW  = VW + 1;

  logic [NREF-1:0] ref_vec, fall_vec, trig;
  assign ref_vec  = {ref_b, ref_a};
  assign fall_vec = {ref_b_fall, ref_a_fall};

  for (genvar r = 0; r < NREF; r++) begin : g_ref
    ref_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (ref_vec[r]),
      .fall_sel (fall_vec[r]),
      .pulse    (trig[r])
    );
  end

  // named trigger events
  logic h_trig, v_trig, h_ld, v_ld, fld_ld, seq_ld, half_tick;
  assign h_trig = slave_en & ((trig[0] & h_src_a) | (trig[1] & h_src_b));
  assign v_trig = slave_en & trig[0];
  assign h_ld   = h_trig & ld_h_en;
  assign v_ld   = v_trig & ld_v_en;
  assign fld_ld = v_trig & ld_fld_en;
  assign seq_ld = v_trig & ld_seq_en;

  line_counter #(.HW(HW), .SW(SW)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_len  (line_len),
    .hs_width  (hs_width),
    .load      (h_ld),
    .load_val  (h_ofs),
    .half_tick (half_tick),
    .hsync     (hsync)
  );

  field_counter #(.VW(VW), .VHW(VHW)) u_field (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_lines (field_lines),
    .seq_long    (seq_long),
    .half_tick   (half_tick),
    .v_load      (v_ld),
    .v_load_val  (VHW'(v_ofs)),
    .fld_clear   (fld_ld),
    .seq_clear   (seq_ld),
    .vsync       (vsync),
    .field_odd   (field_odd),
    .seq_phase   (seq_phase)
  );

  // R6: zero offset puts hsync in the load cycle
  a_r6_zero_ofs: assert property (@(posedge clk) disable iff (!rst_n)
    (h_ld && h_ofs == '0 && hs_width != '0) |=> hsync);
  // R7: zero offset puts vsync in the load cycle
  a_r7_zero_ofs: assert property (@(posedge clk) disable iff (!rst_n)
    (v_ld && v_ofs == '0) |=> vsync);
  // R8: field clear reaches the output
  a_r8_field_out: assert property (@(posedge clk) disable iff (!rst_n)
    fld_ld |=> !field_odd);

endmodule

// File: tb/raster_sync_gen_tb.sv
module raster_sync_gen_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, slave_en, ref_a, ref_b, ref_a_fall, ref_b_fall;
  logic h_src_a, h_src_b, ld_h_en, ld_v_en, ld_fld_en, ld_seq_en, seq_long;
  logic [10:0] line_len, h_ofs;
  logic [9:0]  field_lines;
  logic [7:0]  hs_width;
  logic [4:0]  v_ofs;
  logic hsync, vsync, field_odd;
  logic [1:0] seq_phase;

  raster_sync_gen u_dut (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .ref_a(ref_a), .ref_b(ref_b),
    .ref_a_fall(ref_a_fall), .ref_b_fall(ref_b_fall), .h_src_a(h_src_a),
    .h_src_b(h_src_b), .ld_h_en(ld_h_en), .ld_v_en(ld_v_en), .ld_fld_en(ld_fld_en),
    .ld_seq_en(ld_seq_en), .seq_long(seq_long), .line_len(line_len),
    .field_lines(field_lines), .hs_width(hs_width), .h_ofs(h_ofs), .v_ofs(v_ofs),
    .hsync(hsync), .vsync(vsync), .field_odd(field_odd), .seq_phase(seq_phase)
  );

  typedef struct {
    int    cyc;
    int    sig;   // 0 hsync, 1 vsync, 2 field_odd, 3 seq_phase
    int    val;
    string tag;
  } exp_t;

  exp_t sb[$];
  exp_t mon_item;
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 0;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic int observe(int sig);
    case (sig)
      0: return int'(hsync);
      1: return int'(vsync);
      2: return int'(field_odd);
      default: return int'(seq_phase);
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp_v, string what);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s %s at cyc %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp_v);
    end
  endtask

  // driver side: sorted insert of expected items
  task automatic expect_at(int c, int sig, int val, string tag);
    exp_t it;
    int i = 0;
    it.cyc = c; it.sig = sig; it.val = val; it.tag = tag;
    while (i < sb.size() && sb[i].cyc <= c) i++;
    sb.insert(i, it);
  endtask

  // monitor side
  always @(negedge clk) begin
    if (rst_n && !done) begin
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
        mon_item = sb.pop_front();
        if (mon_item.cyc != cyc)
          chk(mon_item.tag, cyc, mon_item.cyc, "missed sample cycle");
        else
          chk(mon_item.tag, observe(mon_item.sig), mon_item.val,
              $sformatf("signal %0d", mon_item.sig));
      end
    end
  end

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", int'(hsync), 1, "hsync in reset");
    chk("R1", int'(vsync), 1, "vsync in reset");
    chk("R1", int'(field_odd), 0, "field in reset");
    chk("R1", int'(seq_phase), 0, "seq in reset");
    rst_n = 1'b1;
  endtask

  task automatic base_cfg();
    slave_en = 0; ref_a = 0; ref_b = 0; ref_a_fall = 0; ref_b_fall = 0;
    h_src_a = 0; h_src_b = 0; ld_h_en = 0; ld_v_en = 0; ld_fld_en = 0; ld_seq_en = 0;
    seq_long = 0; line_len = 11'd20; field_lines = 10'd5; hs_width = 8'd3;
    h_ofs = 11'd0; v_ofs = 5'd0;
  endtask

  initial begin
    rst_n = 1'b0;
    base_cfg();

    // Phase A: free run, four-field sequence, slave mode off
    h_ofs = 11'd7; v_ofs = 5'd5;
    h_src_a = 1; ld_h_en = 1; ld_v_en = 1; ld_fld_en = 1; ld_seq_en = 1;
    apply_reset();
    expect_at(19, 0, 0, "R2");  expect_at(20, 0, 1, "R2");
    expect_at(22, 0, 1, "R2");  expect_at(23, 0, 0, "R2");
    expect_at(99, 1, 0, "R3");  expect_at(100, 1, 1, "R3");
    expect_at(109, 1, 1, "R3"); expect_at(110, 1, 0, "R3");
    expect_at(99, 2, 0, "R4");  expect_at(100, 2, 1, "R4");
    expect_at(199, 3, 0, "R4"); expect_at(200, 3, 1, "R4");
    expect_at(399, 3, 1, "R4"); expect_at(400, 3, 0, "R4");
    expect_at(260, 0, 1, "R9"); expect_at(261, 0, 1, "R9");
    expect_at(300, 1, 1, "R9"); expect_at(300, 2, 1, "R9");
    wait_cyc(250); ref_a = 1;   // ignored: slave mode off
    drain();

    // Phase B: eight-field sequence
    base_cfg(); seq_long = 1;
    apply_reset();
    expect_at(599, 3, 2, "R4"); expect_at(600, 3, 3, "R4");
    expect_at(800, 3, 0, "R4");
    drain();

    // Phase C: horizontal reloads from both inputs
    base_cfg();
    slave_en = 1; h_src_a = 1; h_src_b = 1; ld_h_en = 1;
    ref_b_fall = 1; ref_b = 1; h_ofs = 11'd5;
    apply_reset();
    expect_at(20, 0, 1, "R5");  // rising on ref_b after reset is not selected
    expect_at(60, 0, 0, "R6");  expect_at(67, 0, 0, "R6");
    expect_at(68, 0, 1, "R6");  expect_at(70, 0, 1, "R6");
    expect_at(71, 0, 0, "R6");
    expect_at(97, 1, 0, "R3");  expect_at(98, 1, 1, "R3");
    expect_at(98, 2, 1, "R4");
    expect_at(132, 0, 0, "R5"); expect_at(133, 0, 1, "R6");
    expect_at(135, 0, 1, "R6"); expect_at(136, 0, 0, "R6");
    expect_at(148, 0, 0, "R5"); expect_at(150, 0, 0, "R5");
    expect_at(153, 0, 1, "R5");
    expect_at(202, 1, 0, "R3"); expect_at(203, 1, 1, "R3");
    expect_at(203, 2, 0, "R4");
    expect_at(202, 3, 0, "R4"); expect_at(203, 3, 1, "R4");
    wait_cyc(50);  ref_a = 1;       // rising, selected
    wait_cyc(100); h_ofs = 11'd0;
    wait_cyc(130); ref_b = 0;       // falling, selected
    wait_cyc(145); ref_a = 0;       // falling, not selected
    drain();

    // Phase D: vertical, field and sequence reloads
    base_cfg();
    slave_en = 1; h_src_a = 1; ld_v_en = 1; ld_fld_en = 1; ld_seq_en = 1;
    field_lines = 10'd20; h_ofs = 11'd7; v_ofs = 5'd31;
    apply_reset();
    expect_at(1199, 1, 0, "R3"); expect_at(1200, 1, 1, "R3");
    expect_at(1200, 2, 1, "R4"); expect_at(1200, 3, 1, "R4");
    expect_at(1208, 1, 0, "R7");
    expect_at(1208, 2, 0, "R8"); expect_at(1208, 3, 0, "R8");
    expect_at(1220, 0, 1, "R9");
    expect_at(1289, 1, 0, "R7"); expect_at(1290, 1, 1, "R7");
    expect_at(1290, 2, 1, "R4"); expect_at(1290, 3, 0, "R4");
    expect_at(1299, 2, 1, "R5");
    expect_at(1335, 1, 0, "R7"); expect_at(1336, 1, 1, "R7");
    expect_at(1336, 2, 0, "R8");
    expect_at(1339, 1, 1, "R7"); expect_at(1340, 1, 0, "R7");
    wait_cyc(1205); ref_a = 1;      // rising, selected
    wait_cyc(1295); ref_a = 0;      // falling, not selected
    wait_cyc(1300); v_ofs = 5'd0;
    wait_cyc(1333); ref_a = 1;
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog R1-R9 run: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule